// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Chain

This block arbitrates external interrupt requests by physical position. A row of identical links is wired in series between the CPU and the far end of the chain. The CPU sees a single request line. It issues an acknowledge pulse and an end-of-service pulse. Each link that holds a pending or active interrupt stops the acknowledge from travelling further. The result is that the link nearest the CPU always wins. The winning link returns its 16-bit identifier on the vector output one cycle after the acknowledge.

A link that takes the acknowledge moves from pending to in-service. It keeps the acknowledge blocked from the links behind it until an end-of-service pulse reaches it. The end-of-service pulse passes through every link that is not in service and is consumed by the first one that is. A higher-priority link may therefore interrupt a lower one that is already being served. Services then end in the reverse order in which they were granted.

Each device gives a one-cycle raise pulse to post a request. The wrapper chains `N_NODES` links. Link k carries the identifier `ID_BASE + k`, and link 0 sits nearest the CPU.

Top module: `irq_daisy_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all pending and in-service state clears. After that edge `cpu_irq` and `vec_valid` are 0.
- R2: A `dev_raise[k]` pulse makes link k pending from the next edge on. `cpu_irq` is high whenever any link is pending.
- R3: A `cpu_ack` pulse grants the lowest-index link that is pending and not in service, provided no lower-index link is pending or in service. In the cycle after the acknowledge, `vec_valid` is 1 and `vec_data` equals `ID_BASE + k`.
- R4: Links behind the granted one keep their pending requests across the acknowledge. Later acknowledges serve them in index order.
- R5: While a link is in service, an acknowledge reaches no link behind it, and `vec_valid` stays 0.
- R6: A `cpu_end` pulse clears in-service on the lowest-index link that is in service, and on no other link. This reopens the chain behind that link.
- R7: An acknowledge that meets no pending link produces no vector.
- R8: Raising an already pending link does not create a second request. It yields exactly one vector.
- R9: A link ahead of an in-service link can be granted (nesting). The first end pulse then closes the newer, upstream service.
- R10: A raise on a link that is in service stays pending. It blocks the chain and is granted only after that link's own service has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_raise | input | N_NODES | One-cycle request pulse per link, bit 0 nearest the CPU |
| cpu_ack | input | 1 | Acknowledge pulse entering the chain |
| cpu_end | input | 1 | End-of-service pulse entering the chain |
| cpu_irq | output | 1 | Any link pending |
| vec_data | output | ID_W | Identifier of the link granted in the previous cycle, zero otherwise |
| vec_valid | output | 1 | vec_data holds a granted identifier |

## Verification
The bench sweeps every combination of simultaneous raises across four links and drains each one by acknowledge and end pulses. A wrong priority would show up as identifiers out of index order, and a lost downstream request as a missing vector. Directed sequences cover several cases:
- a raise on an in-service link, which must not cause a grant before its own end;
- a nested upstream grant, where an end pulse consumed by the wrong link would leave the chain blocked;
- duplicate raises, which a counting design would turn into two vectors.

A long pseudo-random stream of raise, acknowledge and end pulses is then compared against a behavioural model of the chain.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned DEF_ID_W  = 16;
  localparam int unsigned DEF_NODES = 4;

  typedef struct packed {
    logic pend;
    logic insvc;
  } link_state_t;
endpackage

// File: rtl/prio_link.sv
module prio_link
  import irq_chain_pkg::*;
#(
  parameter int unsigned ID_W = DEF_ID_W,
  parameter logic [ID_W-1:0] NODE_ID = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            raise,
  input  logic            ack_up,
  output logic            ack_dn,
  input  logic            end_up,
  output logic            end_dn,
  input  logic            irq_from_dn,
  output logic            irq_up,
  output logic            grant,
  output logic            pend_o,
  output logic            insvc_o,
  output logic [ID_W-1:0] vec_q,
  output logic            vld_q
);
  link_state_t st;
  logic        end_hit;

  assign grant   = ack_up & st.pend & ~st.insvc;
  assign end_hit = end_up & st.insvc;
  assign ack_dn  = ack_up & ~(st.pend | st.insvc);
  assign end_dn  = end_up & ~st.insvc;
  assign irq_up  = st.pend | irq_from_dn;
  assign pend_o  = st.pend;
  assign insvc_o = st.insvc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st.pend  <= (st.pend & ~grant) | raise;
      st.insvc <= (st.insvc & ~end_hit) | grant;
      vec_q    <= grant ? NODE_ID : '0;
      vld_q    <= grant;
    end
  end
endmodule

// File: rtl/vec_merge.sv
module vec_merge #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16
) (
  input  logic [N-1:0]   vld_in,
  input  logic [N*W-1:0] data_in,
  output logic           vld_out,
  output logic [W-1:0]   data_out
);
  logic [W-1:0] acc [N+1];
  assign acc[0] = '0;
  for (genvar k = 0; k < N; k++) begin : g_or
    assign acc[k+1] = acc[k] | data_in[k*W +: W];
  end
  assign data_out = acc[N];
  assign vld_out  = |vld_in;
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int unsigned N_NODES = DEF_NODES,
  parameter int unsigned ID_W    = DEF_ID_W,
  parameter logic [ID_W-1:0] ID_BASE = 16'hA500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_NODES-1:0] dev_raise,
  input  logic               cpu_ack,
  input  logic               cpu_end,
  output logic               cpu_irq,
  output logic [ID_W-1:0]    vec_data,
  output logic               vec_valid
);
  localparam int unsigned BUS_W = N_NODES * ID_W;

  logic [N_NODES:0]   ack_c, end_c, irq_c;
  logic [N_NODES-1:0] grant_v, pend_v, svc_v, vld_v;
  logic [BUS_W-1:0]   vec_bus;

  assign ack_c[0]       = cpu_ack;
  assign end_c[0]       = cpu_end;
  assign irq_c[N_NODES] = 1'b0;
  assign cpu_irq        = irq_c[0];

  for (genvar k = 0; k < N_NODES; k++) begin : g_link
    localparam logic [ID_W-1:0] LINK_ID = ID_BASE + ID_W'(k);
    prio_link #(.ID_W(ID_W), .NODE_ID(LINK_ID)) u_link (
      .clk        (clk),
      .rst        (rst),
      .raise      (dev_raise[k]),
      .ack_up     (ack_c[k]),
      .ack_dn     (ack_c[k+1]),
      .end_up     (end_c[k]),
      .end_dn     (end_c[k+1]),
      .irq_from_dn(irq_c[k+1]),
      .irq_up     (irq_c[k]),
      .grant      (grant_v[k]),
      .pend_o     (pend_v[k]),
      .insvc_o    (svc_v[k]),
      .vec_q      (vec_bus[k*ID_W +: ID_W]),
      .vld_q      (vld_v[k])
    );
  end

  vec_merge #(.N(N_NODES), .W(ID_W)) u_merge (
    .vld_in  (vld_v),
    .data_in (vec_bus),
    .vld_out (vec_valid),
    .data_out(vec_data)
  );
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cpu_ack,
  input logic         cpu_end,
  input logic         cpu_irq,
  input logic         vec_valid,
  input logic [N-1:0] pend,
  input logic [N-1:0] svc,
  input logic [N-1:0] grant
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!vec_valid && pend == '0 && svc == '0));

  assert_pending_irq_R2: assert property (@(posedge clk) disable iff (rst)
    (|pend) |-> cpu_irq);

  assert_grant_priority_R3: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> ($countones(grant) == 1 && ((grant - ONE) & (pend | svc)) == '0));

  assert_vec_follows_grant_R3: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(|grant));

  assert_blocked_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && svc[0]) |-> (grant == '0));

  assert_end_lowest_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_end && !cpu_ack && (|svc)) |=> (svc == ($past(svc) & ($past(svc) - ONE))));

  assert_empty_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && pend == '0) |=> !vec_valid);
endmodule

bind irq_daisy_chain irq_chain_checker #(.N(N_NODES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_ack  (cpu_ack),
  .cpu_end  (cpu_end),
  .cpu_irq  (cpu_irq),
  .vec_valid(vec_valid),
  .pend     (pend_v),
  .svc      (svc_v),
  .grant    (grant_v)
);

// File: tb/test_irq_daisy_chain.sv
`timescale 1ns/1ps
module test_irq_daisy_chain;
  localparam int N = 4;
  localparam logic [15:0] BASE = 16'hA500;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] dev_raise = '0;
  logic         cpu_ack = 1'b0;
  logic         cpu_end = 1'b0;
  logic         cpu_irq;
  logic [15:0]  vec_data;
  logic         vec_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [N-1:0] m_pend, m_svc;

  always #2.5 clk = ~clk;

  irq_daisy_chain #(.N_NODES(N), .ID_W(16), .ID_BASE(BASE)) i_irq_daisy_chain (
    .clk(clk), .rst(rst), .dev_raise(dev_raise), .cpu_ack(cpu_ack),
    .cpu_end(cpu_end), .cpu_irq(cpu_irq), .vec_data(vec_data), .vec_valid(vec_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 100000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; dev_raise = '0; cpu_ack = 1'b0; cpu_end = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R1", {31'b0, cpu_irq}, 0, "cpu_irq after reset");
    chk("R1", {31'b0, vec_valid}, 0, "vec_valid after reset");
    rst = 1'b0;
    m_pend = '0; m_svc = '0;
  endtask

  // One cycle: drive, clock, update model, compare. tag "" picks the tag by case.
  task automatic step(input logic [N-1:0] r, input logic a, input logic e, input string tag);
    int g, ed;
    string t;
    g = -1; ed = -1;
    if (a) begin
      for (int i = 0; i < N; i++) begin
        if (m_svc[i]) break;
        if (m_pend[i]) begin g = i; break; end
      end
    end
    if (e) begin
      for (int i = 0; i < N; i++) if (m_svc[i]) begin ed = i; break; end
    end
    dev_raise = r; cpu_ack = a; cpu_end = e;
    @(posedge clk); #1;
    dev_raise = '0; cpu_ack = 1'b0; cpu_end = 1'b0;
    if (ed >= 0) m_svc[ed] = 1'b0;
    if (g >= 0) begin m_svc[g] = 1'b1; m_pend[g] = 1'b0; end
    m_pend = m_pend | r;
    t = tag;
    if (t == "") begin
      if (g >= 0)       t = (g > 0) ? "R4" : "R3";
      else if (a && m_svc != '0) t = "R5";
      else if (a)       t = "R7";
      else if (e)       t = "R6";
      else              t = "R2";
    end
    chk(t, {31'b0, vec_valid}, {31'b0, g >= 0}, "vec_valid");
    if (g >= 0) chk(t, {16'b0, vec_data}, {16'b0, BASE + 16'(g)}, "vec_data");
    chk((r != '0) ? "R2" : t, {31'b0, cpu_irq}, {31'b0, |m_pend}, "cpu_irq");
  endtask

  initial begin
    logic [15:0] lf;
    do_reset();
    // R2/R3/R4/R6: every raise pattern, drained in priority order
    for (int m = 0; m < (1 << N); m++) begin
      do_reset();
      step(N'(m), 1'b0, 1'b0, "R2");
      for (int k = 0; k < N + 1; k++) begin
        step('0, 1'b1, 1'b0, "");
        step('0, 1'b0, 1'b1, "R6");
      end
    end
    // R1: reset drops a pending request
    do_reset();
    step(4'b0100, 1'b0, 1'b0, "R2");
    do_reset();
    step('0, 1'b1, 1'b0, "R1");
    // R5: service at link 1 blocks link 3; R6 reopens
    do_reset();
    step(4'b1010, 1'b0, 1'b0, "R2");
    step('0, 1'b1, 1'b0, "R3");
    step('0, 1'b1, 1'b0, "R5");
    step('0, 1'b0, 1'b1, "R6");
    step('0, 1'b1, 1'b0, "R6");
    // R7: acknowledge with nothing pending
    do_reset();
    step('0, 1'b1, 1'b0, "R7");
    // R8: duplicate raise gives one vector
    do_reset();
    step(4'b0100, 1'b0, 1'b0, "R8");
    step(4'b0100, 1'b0, 1'b0, "R8");
    step('0, 1'b1, 1'b0, "R8");
    step('0, 1'b0, 1'b1, "R8");
    step('0, 1'b1, 1'b0, "R8");
    // R9: nested upstream grant, ends in reverse order
    do_reset();
    step(4'b1000, 1'b0, 1'b0, "R9");
    step('0, 1'b1, 1'b0, "R9");
    step(4'b0001, 1'b0, 1'b0, "R9");
    step('0, 1'b1, 1'b0, "R9");
    step('0, 1'b0, 1'b1, "R9");
    step(4'b0010, 1'b0, 1'b0, "R9");
    step('0, 1'b1, 1'b0, "R9");
    // R10: re-raise while in service waits for its own end
    do_reset();
    step(4'b0010, 1'b0, 1'b0, "R10");
    step('0, 1'b1, 1'b0, "R10");
    step(4'b0110, 1'b0, 1'b0, "R10");
    step('0, 1'b1, 1'b0, "R10");
    step('0, 1'b0, 1'b1, "R10");
    step('0, 1'b1, 1'b0, "R10");
    // Mixed pseudo-random traffic
    do_reset();
    lf = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0] & {N{lf[4] & lf[5]}}, lf[6] & lf[7], lf[8] & lf[9] & lf[11], "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule